// File: doc/BRIEF.md
# Write-Protect and Status Register Unit

This unit sits beside the serial controller of an SPI memory slave. It keeps the 8-bit configuration byte and the write enable latch, and it runs the four commands that touch them: set latch, clear latch, read configuration and write configuration. The controller shifts the bits. It hands this unit the decoded opcode byte, each data byte that follows a configuration write, a strobe for every memory byte it stores, and a strobe when chip select rises.

For every memory address that the controller presents, the unit answers at once whether a write there is allowed. That answer combines three layers of protection. The software latch gates every write. The two range bits guard the top quarter, the top half or all of the array. The protect-enable bit, together with the active-low protect pin, can lock the configuration byte itself.

Top module: `wp_status_unit`

## Requirements
- R1: After reset the configuration byte reads 0x00, writeAllowed is 0 and readStatusActive is 0.
- R2: Opcode 0x06 sets the latch (bit 1 of statusOut) on the next clock. Opcode 0x04 clears it on the next clock.
- R3: Byte layout: bit 7 is protect-enable, bits 3:2 are the range bits and bit 1 is the latch. Bits 6:4 and bit 0 always read 0. A configuration write stores data bits 7, 3 and 2 only. It never changes the latch through data bit 1.
- R4: A configuration data byte is applied only if the latch is 1 and it is not the case that protect-enable is 1 while wpN is 0. A blocked byte leaves the register unchanged.
- R5: The range bits select the protected addresses. With 00 nothing is protected. With 01 the two top address bits equal to 11 are protected. With 10 a top address bit of 1 is protected. With 11 every address is protected.
- R6: writeAllowed is 1 only when the latch is 1 and checkAddr lies outside the protected range.
- R7: At csRise the latch clears if, within that select, a memory byte was stored or a configuration byte was applied. Otherwise the latch is left as it was.
- R8: Opcode 0x05 raises readStatusActive on the next clock and holds it until the cycle after csRise. statusOut presents the live byte throughout, so it can be repeated for as long as the clock runs.
- R9: Any other opcode has no effect. A configuration data byte that is not preceded by opcode 0x01 within the same select is ignored.
- R10: After opcode 0x01, only the first data byte of that select is considered. Later bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Opcode byte strobe from the controller |
| cmdOpcode | input | 8 | Decoded opcode byte |
| csRise | input | 1 | Chip select has gone inactive (end of select) |
| statusWrValid | input | 1 | Configuration data byte strobe |
| statusWrData | input | 8 | Configuration data byte |
| memWrStrobe | input | 1 | A memory byte was stored in this select |
| wpN | input | 1 | Active-low protect pin |
| checkAddr | input | ADDR_W | Memory address to be judged |
| writeAllowed | output | 1 | Writing checkAddr is permitted |
| statusOut | output | 8 | Live configuration byte, latch included |
| readStatusActive | output | 1 | A read-configuration command is in progress |

## Verification
The hardest state to reach is a configuration write refused by the pin. Getting there takes a select that sets protect-enable, then a fresh latch, then a second select with wpN low. Only after that can the bench show that the register did not move and that csRise left the latch set. The bench builds this sequence in order. It then releases the pin and shows that the same byte is accepted. Range checks are driven from a table that programs each range setting and probes the addresses just below and at each boundary.

// File: rtl/wpsu_pkg.sv
package wpsu_pkg;
  localparam logic [7:0] OP_SET_LATCH = 8'h06;
  localparam logic [7:0] OP_CLR_LATCH = 8'h04;
  localparam logic [7:0] OP_READ_CFG  = 8'h05;
  localparam logic [7:0] OP_WRITE_CFG = 8'h01;

  // bits of the configuration byte that a write may change
  localparam logic [7:0] CFG_WR_MASK  = 8'h8C;
  localparam int         BIT_PEN      = 7;
  localparam int         BIT_LATCH    = 1;

  typedef struct packed {
    logic setLatch;
    logic clrLatch;
    logic loadCfg;
  } ctl_strobe_t;
endpackage

// File: rtl/wpsu_ctrl.sv
module wpsu_ctrl
  import wpsu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [7:0]  cmdOpcode,
  input  logic        csRise,
  input  logic        statusWrValid,
  input  logic        memWrStrobe,
  input  logic        cfgWrOk,
  output ctl_strobe_t strb,
  output logic        readStatusActive
);
  logic readOn;
  logic cfgArmed;
  logic pendClr;
  logic isSet, isClr, isRead, isWrite;

  always_comb begin
    isSet   = cmdValid && (cmdOpcode == OP_SET_LATCH);
    isClr   = cmdValid && (cmdOpcode == OP_CLR_LATCH);
    isRead  = cmdValid && (cmdOpcode == OP_READ_CFG);
    isWrite = cmdValid && (cmdOpcode == OP_WRITE_CFG);
    strb.setLatch = isSet;
    strb.clrLatch = isClr || (csRise && pendClr);
    strb.loadCfg  = statusWrValid && cfgArmed && cfgWrOk && !csRise;
  end

  always_ff @(posedge clk) begin
    if (!rstN || csRise) begin
      readOn   <= 1'b0;
      cfgArmed <= 1'b0;
      pendClr  <= 1'b0;
    end else begin
      if (isRead)  readOn   <= 1'b1;
      if (isWrite) cfgArmed <= 1'b1;
      // first data byte disarms, applied or not
      if (statusWrValid && cfgArmed) cfgArmed <= 1'b0;
      if (strb.loadCfg || memWrStrobe) pendClr <= 1'b1;
    end
  end

  assign readStatusActive = readOn;
endmodule

// File: rtl/wpsu_regs.sv
module wpsu_regs
  import wpsu_pkg::*;
#(
  parameter int ADDR_W = 18
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strb,
  input  logic [7:0]        statusWrData,
  input  logic              wpN,
  input  logic [ADDR_W-1:0] checkAddr,
  output logic              cfgWrOk,
  output logic              writeAllowed,
  output logic [7:0]        statusOut
);
  localparam int TOP = ADDR_W - 1;

  logic [7:0] cfgReg;
  logic       latch;
  logic [1:0] range;
  logic [1:0] topBits;
  logic       inProt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
      latch  <= 1'b0;
    end else begin
      if (strb.loadCfg)
        cfgReg <= (cfgReg & ~CFG_WR_MASK) | (statusWrData & CFG_WR_MASK);
      if (strb.clrLatch)      latch <= 1'b0;
      else if (strb.setLatch) latch <= 1'b1;
    end
  end

  always_comb begin
    range   = cfgReg[3:2];
    topBits = checkAddr[TOP -: 2];
    unique case (range)
      2'b00:   inProt = 1'b0;
      2'b01:   inProt = (topBits == 2'b11);
      2'b10:   inProt = topBits[1];
      default: inProt = 1'b1;
    endcase
    cfgWrOk      = latch && !(cfgReg[BIT_PEN] && !wpN);
    writeAllowed = latch && !inProt;
    statusOut    = cfgReg | (8'(latch) << BIT_LATCH);
  end
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit
  import wpsu_pkg::*;
#(
  parameter int ADDR_W = 18
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdOpcode,
  input  logic              csRise,
  input  logic              statusWrValid,
  input  logic [7:0]        statusWrData,
  input  logic              memWrStrobe,
  input  logic              wpN,
  input  logic [ADDR_W-1:0] checkAddr,
  output logic              writeAllowed,
  output logic [7:0]        statusOut,
  output logic              readStatusActive
);
  ctl_strobe_t strb;
  logic        cfgWrOk;

  wpsu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOpcode(cmdOpcode),
    .csRise(csRise), .statusWrValid(statusWrValid), .memWrStrobe(memWrStrobe),
    .cfgWrOk(cfgWrOk), .strb(strb), .readStatusActive(readStatusActive)
  );

  wpsu_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .statusWrData(statusWrData),
    .wpN(wpN), .checkAddr(checkAddr), .cfgWrOk(cfgWrOk),
    .writeAllowed(writeAllowed), .statusOut(statusOut)
  );
endmodule

// File: rtl/wp_status_chk.sv
module wp_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [7:0] cmdOpcode,
  input logic       csRise,
  input logic       statusWrValid,
  input logic       wpN,
  input logic       writeAllowed,
  input logic [7:0] statusOut,
  input logic       readStatusActive
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (statusOut == 8'h00 && !readStatusActive));

  assert_set_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOpcode == 8'h06 && !csRise) |=> statusOut[1]);

  assert_clr_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOpcode == 8'h04) |=> !statusOut[1]);

  assert_zero_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[6:4] == 3'b000 && !statusOut[0]));

  assert_pin_lock_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statusWrValid && !wpN && statusOut[7]) |=> $stable(statusOut[7:2]));

  assert_full_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[3:2] == 2'b11) |-> !writeAllowed);

  assert_latch_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    !statusOut[1] |-> !writeAllowed);

  assert_read_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> !readStatusActive);
endmodule

bind wp_status_unit wp_status_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOpcode(cmdOpcode),
  .csRise(csRise), .statusWrValid(statusWrValid), .wpN(wpN),
  .writeAllowed(writeAllowed), .statusOut(statusOut),
  .readStatusActive(readStatusActive)
);

// File: tb/sim_wp_status_unit.sv
module sim_wp_status_unit;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [7:0]    cmdOpcode = 8'h00;
  logic          csRise = 1'b0;
  logic          statusWrValid = 1'b0;
  logic [7:0]    statusWrData = 8'h00;
  logic          memWrStrobe = 1'b0;
  logic          wpN = 1'b1;
  logic [AW-1:0] checkAddr = '0;
  logic          writeAllowed;
  logic [7:0]    statusOut;
  logic          readStatusActive;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  wp_status_unit #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOpcode(cmdOpcode),
    .csRise(csRise), .statusWrValid(statusWrValid), .statusWrData(statusWrData),
    .memWrStrobe(memWrStrobe), .wpN(wpN), .checkAddr(checkAddr),
    .writeAllowed(writeAllowed), .statusOut(statusOut),
    .readStatusActive(readStatusActive)
  );

  // {range[1:0], addr[17:0], expected writeAllowed}
  localparam logic [20:0] VEC [8] = '{
    {2'b00, 18'h3FFFF, 1'b1},
    {2'b01, 18'h2FFFF, 1'b1},
    {2'b01, 18'h30000, 1'b0},
    {2'b01, 18'h00000, 1'b1},
    {2'b10, 18'h1FFFF, 1'b1},
    {2'b10, 18'h20000, 1'b0},
    {2'b10, 18'h3FFFF, 1'b0},
    {2'b11, 18'h00000, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [7:0] op);
    @(negedge clk); cmdValid = 1'b1; cmdOpcode = op;
    @(negedge clk); cmdValid = 1'b0;
  endtask

  task automatic sendData(input logic [7:0] d);
    @(negedge clk); statusWrValid = 1'b1; statusWrData = d;
    @(negedge clk); statusWrValid = 1'b0;
  endtask

  task automatic endSelect();
    @(negedge clk); csRise = 1'b1;
    @(negedge clk); csRise = 1'b0;
  endtask

  task automatic memWrite();
    @(negedge clk); memWrStrobe = 1'b1;
    @(negedge clk); memWrStrobe = 1'b0;
  endtask

  task automatic writeCfg(input logic [7:0] d);
    sendCmd(8'h06); sendCmd(8'h01); sendData(d); endSelect();
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 status", statusOut, 8'h00);
    check("R1 writeAllowed", writeAllowed, 0);
    check("R1 readActive", readStatusActive, 0);

    // range table
    for (int i = 0; i < 8; i++) begin
      writeCfg({4'b0, VEC[i][20:19], 2'b00});
      sendCmd(8'h06);
      checkAddr = VEC[i][18:1];
      @(negedge clk);
      check($sformatf("R5 vec%0d", i), writeAllowed, VEC[i][0]);
    end
    writeCfg(8'h00);
    endSelect();

    // R2 latch set / clear
    sendCmd(8'h06);
    check("R2 set", statusOut, 8'h02);
    sendCmd(8'h04);
    check("R2 clear", statusOut, 8'h00);

    // R9 unknown opcode, stray data byte
    sendCmd(8'h06);
    sendCmd(8'h03);
    check("R9 unknown opcode", statusOut, 8'h02);
    sendData(8'h8C);
    check("R9 stray data", statusOut, 8'h02);
    endSelect();
    check("R7 no completed write keeps latch", statusOut, 8'h02);

    // R3 layout and mask, R7 clear after config write
    sendCmd(8'h01); sendData(8'hFF);
    check("R3 masked write", statusOut, 8'h8E);
    endSelect();
    check("R7 clear after cfg write", statusOut, 8'h8C);

    // R4 pin lock with protect-enable set
    wpN = 1'b0;
    sendCmd(8'h06); sendCmd(8'h01); sendData(8'h00);
    check("R4 locked write ignored", statusOut, 8'h8E);
    endSelect();
    check("R7 blocked write keeps latch", statusOut, 8'h8E);
    wpN = 1'b1;
    sendCmd(8'h01); sendData(8'h00); endSelect();
    check("R4 pin released write applied", statusOut, 8'h00);

    // R10 only first data byte
    sendCmd(8'h06); sendCmd(8'h01); sendData(8'h04); sendData(8'h08);
    check("R10 first byte only", statusOut, 8'h06);
    endSelect();

    // R7 memory write then select end
    sendCmd(8'h06); endSelect();
    checkAddr = 18'h00010;
    @(negedge clk);
    check("R6 allowed outside range", writeAllowed, 1);
    memWrite();
    check("R7 latch held before end", statusOut, 8'h06);
    endSelect();
    check("R7 clear after mem write", statusOut, 8'h04);
    check("R6 no latch no write", writeAllowed, 0);

    // R8 read configuration
    sendCmd(8'h06); endSelect();
    sendCmd(8'h05);
    check("R8 active", readStatusActive, 1);
    repeat (5) @(negedge clk);
    check("R8 still active", readStatusActive, 1);
    check("R8 live byte", statusOut, 8'h06);
    endSelect();
    check("R8 ends at select end", readStatusActive, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule